// File: doc/BRIEF.md
# Atomic Bit Set/Clear Output Port

This block holds the output data for one general-purpose output port of up to sixteen pins and drives the pins straight from its flops. Software reaches it through a simple single-cycle register bus that carries an address, a write strobe with write data, and a read strobe with read data. Two words are decoded. The first is an ordinary output data word that can be read and written. The second is a write-only command word. Its lower half raises pins and its upper half lowers them, so one bus write can change any group of pins without disturbing the rest and without a read-modify-write sequence.

Only some pin positions are built, as chosen by a mask parameter. The default builds pins 0 to 6 and 13 to 15. An unbuilt position has no flop. It reads as zero, and every write to it, through either word, is ignored. Every read of the command word returns zero. Accesses to any other address read zero and change nothing.

Top module: `atomic_outport`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, the output data clears to all zeros on each clock edge. After reset, `pins` and a read of the data word both return 0.
- R2: A write to the data word at byte address 0x814 loads `wr_data[15:0]` into the implemented positions. A read of that address returns the stored value in bits 15:0 and zero in bits 31:16.
- R3: In a write to the command word at byte address 0x818, a 1 in bit y of `wr_data` (y in 0..15) drives output bit y to 1.
- R4: In a write to the command word, a 1 in bit 16+y of `wr_data` drives output bit y to 0.
- R5: In a command-word write, an output bit whose raise bit and lower bit are both 0 keeps its value.
- R6: When one command-word write has both bit y and bit 16+y at 1, output bit y ends at 1.
- R7: Every read of the command-word address returns 0 in all 32 bits, whatever was written before.
- R8: Only the positions set in `PIN_MASK` exist (default 0xE07F: pins 0–6 and 13–15). Unbuilt positions always drive and read 0. Writes to them through either word, including raise bits 12:7 and lower bits 28:23, have no effect on any output.
- R9: A write changes `pins` on the clock edge that accepts the strobe. The new value is visible in the cycle after the strobe, and the old value holds before that edge.
- R10: A read of any address other than 0x814 and 0x818 returns 0, and a write to such an address leaves `pins` unchanged. A read with `rd_en` low returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Byte address of the access |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, combinational from `addr` and `rd_en` |
| pins | output | 16 | Registered output data driving the pins |

## Verification
The hardest case to reach is a long run of command-word writes. Across that run every built bit has to keep its value through many writes that do not name it, while raise and lower bits land at the same time on the same and on different pins. A few directed writes cannot show this. The bench therefore applies thousands of pseudo-random command words and compares each cycle against an arithmetic model. It adds per-bit sweeps in which both requests are set together. It also sweeps every other word address, plus unaligned neighbours of the two real addresses, with all-ones data, to show that those writes leave `pins` unchanged.

// File: rtl/outport_pkg.sv
package outport_pkg;

   // Which register, if any, an access selects
   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_DATA   = 2'd1,
      SEL_SETCLR = 2'd2
   } reg_sel_e;

   // Next value of one output bit: load beats raise, raise beats lower
   function automatic logic next_bit(input logic cur, input logic ld, input logic ld_val,
                                     input logic raise, input logic lower);
      logic nv;
      if (ld)         nv = ld_val;
      else if (raise) nv = 1'b1;
      else if (lower) nv = 1'b0;
      else            nv = cur;
      return nv;
   endfunction

endpackage

// File: rtl/outport_decode.sv
module outport_decode
   import outport_pkg::*;
#(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned DATA_OFS   = 32'h814,
   parameter int unsigned SETCLR_OFS = 32'h818
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   localparam logic [ADDR_W-1:0] DATA_A   = ADDR_W'(DATA_OFS);
   localparam logic [ADDR_W-1:0] SETCLR_A = ADDR_W'(SETCLR_OFS);

   always_comb begin
      if (addr == DATA_A)        sel = SEL_DATA;
      else if (addr == SETCLR_A) sel = SEL_SETCLR;
      else                       sel = SEL_NONE;
   end
endmodule

// File: rtl/outport_bit.sv
module outport_bit
   import outport_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic ld,
   input  logic ld_val,
   input  logic raise,
   input  logic lower,
   output logic q
);
   always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= next_bit(q, ld, ld_val, raise, lower);
   end

   // R6: a raise request wins over a simultaneous lower request
   a_r6_raise_wins: assert property (@(posedge clk) disable iff (rst)
      (!ld && raise && lower) |=> q);
   // R4: a lone lower request clears the bit
   a_r4_lower_clears: assert property (@(posedge clk) disable iff (rst)
      (!ld && !raise && lower) |=> !q);
   // R5: no request keeps the bit
   a_r5_hold: assert property (@(posedge clk) disable iff (rst)
      (!ld && !raise && !lower) |=> $stable(q));
endmodule

// File: rtl/atomic_outport.sv
module atomic_outport
   import outport_pkg::*;
#(
   parameter int unsigned PORT_W     = 16,
   parameter int unsigned ADDR_W     = 12,
   parameter logic [15:0] PIN_MASK   = 16'hE07F,
   parameter int unsigned DATA_OFS   = 32'h814,
   parameter int unsigned SETCLR_OFS = 32'h818
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                wr_en,
   input  logic [2*PORT_W-1:0] wr_data,
   input  logic                rd_en,
   output logic [2*PORT_W-1:0] rd_data,
   output logic [PORT_W-1:0]   pins
);
   localparam int unsigned BUS_W = 2 * PORT_W;
   localparam logic [PORT_W-1:0] MASK = PIN_MASK[PORT_W-1:0];

   // Elaboration-time parameter checks
   if (PORT_W < 1 || PORT_W > 16) begin : g_bad_width
      $error("PORT_W must lie in 1..16");
   end
   if (DATA_OFS == SETCLR_OFS) begin : g_bad_ofs
      $error("data and command word offsets must differ");
   end
   if (ADDR_W < 2 || ADDR_W > 31) begin : g_bad_aw
      $error("ADDR_W must lie in 2..31");
   end
   if ((DATA_OFS >> ADDR_W) != 0 || (SETCLR_OFS >> ADDR_W) != 0) begin : g_bad_fit
      $error("offsets must fit in ADDR_W bits");
   end

   reg_sel_e sel;

   outport_decode #(
      .ADDR_W    (ADDR_W),
      .DATA_OFS  (DATA_OFS),
      .SETCLR_OFS(SETCLR_OFS)
   ) u_decode (
      .addr(addr),
      .sel (sel)
   );

   logic                ld_stb;
   logic                cmd_stb;
   logic [PORT_W-1:0]   raise_v;
   logic [PORT_W-1:0]   lower_v;
   logic [PORT_W-1:0]   odr;

   assign ld_stb  = wr_en && (sel == SEL_DATA);
   assign cmd_stb = wr_en && (sel == SEL_SETCLR);
   assign raise_v = cmd_stb ? wr_data[PORT_W-1:0]     : '0;
   assign lower_v = cmd_stb ? wr_data[BUS_W-1:PORT_W] : '0;

   // One flop per built pin; unbuilt positions are tied low
   for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      if (MASK[i]) begin : g_impl
         outport_bit u_bit (
            .clk   (clk),
            .rst   (rst),
            .ld    (ld_stb),
            .ld_val(wr_data[i]),
            .raise (raise_v[i]),
            .lower (lower_v[i]),
            .q     (odr[i])
         );
      end else begin : g_rsvd
         assign odr[i] = 1'b0;
      end
   end

   assign pins = odr;

   // Read path: only the data word returns content
   always_comb begin
      rd_data = '0;
      if (rd_en && sel == SEL_DATA) rd_data[PORT_W-1:0] = odr;
   end

   // R8: unbuilt positions never drive a 1
   a_r8_rsvd_low: assert property (@(posedge clk) disable iff (rst)
      (pins & ~MASK) == '0);
   // R3: raised built pins read 1 after the write
   a_r3_raise: assert property (@(posedge clk) disable iff (rst)
      cmd_stb |=> ((pins & $past(wr_data[PORT_W-1:0] & MASK)) == $past(wr_data[PORT_W-1:0] & MASK)));
   // R4: lowered-only pins read 0 after the write
   a_r4_lower: assert property (@(posedge clk) disable iff (rst)
      cmd_stb |=> ((pins & $past(wr_data[BUS_W-1:PORT_W] & ~wr_data[PORT_W-1:0])) == '0));
   // R5: pins not named by a command write keep their value
   a_r5_keep: assert property (@(posedge clk) disable iff (rst)
      cmd_stb |=> (((pins ^ $past(pins)) & ~$past(wr_data[PORT_W-1:0] | wr_data[BUS_W-1:PORT_W])) == '0));
   // R7: command word reads as zero
   a_r7_cmd_reads_zero: assert property (@(posedge clk) disable iff (rst)
      (rd_en && sel == SEL_SETCLR) |-> (rd_data == '0));
   // R10: writes elsewhere leave the pins alone
   a_r10_undef_write: assert property (@(posedge clk) disable iff (rst)
      (wr_en && sel == SEL_NONE) |=> $stable(pins));
   // R2: data writes load the masked value
   a_r2_load: assert property (@(posedge clk) disable iff (rst)
      ld_stb |=> (pins == $past(wr_data[PORT_W-1:0] & MASK)));
endmodule

// File: tb/atomic_outport_bench.sv
module atomic_outport_bench;
   localparam logic [15:0] MASK = 16'hE07F;
   localparam logic [11:0] A_DATA = 12'h814;
   localparam logic [11:0] A_CMD  = 12'h818;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic [15:0] pins;

   int total = 0;
   int bad = 0;
   logic [15:0] model = '0;
   logic done = 1'b0;

   always #2 clk = ~clk;

   atomic_outport u_atomic_outport (
      .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .pins(pins)
   );

   task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive a write at the falling edge, let one rising edge accept it
   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rd_data;
      rd_en = 1'b0;
   endtask

   function automatic logic [15:0] apply_cmd(input logic [15:0] cur, input logic [31:0] d);
      return (cur & ~(d[31:16] & MASK)) | (d[15:0] & MASK);
   endfunction

   initial begin
      logic [31:0] rv;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      check32("R1 pins after reset", {16'h0, pins}, 32'h0);
      bus_read(A_DATA, rv);
      check32("R1 data read after reset", rv, 32'h0);

      // R2 / R8: sweep of data word values, reserved bits dropped
      for (int i = 0; i < 8192; i++) begin
         logic [15:0] v;
         v = 16'(i * 8 + (i >> 9));
         bus_write(A_DATA, {16'hFFFF, v});
         model = v & MASK;
         check32("R2 pins after data write", {16'h0, pins}, {16'h0, model});
         bus_read(A_DATA, rv);
         check32("R2/R8 data read", rv, {16'h0, model});
      end

      // R9: old value holds before the accepting edge, new value after
      bus_write(A_DATA, 32'h0);
      model = '0;
      @(negedge clk);
      addr = A_CMD; wr_data = 32'h0000_0041; wr_en = 1'b1;
      #1 check32("R9 pins before edge", {16'h0, pins}, 32'h0);
      @(negedge clk);
      wr_en = 1'b0;
      model = 16'h0041;
      check32("R9 pins after edge", {16'h0, pins}, {16'h0, model});

      // R3 / R4 / R6: per-bit sweeps from both start states
      for (int y = 0; y < 16; y++) begin
         logic [15:0] b;
         b = 16'(1) << y;
         bus_write(A_DATA, 32'h0);
         bus_write(A_CMD, {16'h0, b});
         check32("R3 raise single bit", {16'h0, pins}, {16'h0, b & MASK});
         bus_write(A_DATA, 32'hFFFF);
         bus_write(A_CMD, {b, 16'h0});
         check32("R4 lower single bit", {16'h0, pins}, {16'h0, MASK & ~b});
         bus_write(A_DATA, 32'h0);
         bus_write(A_CMD, {b, b});
         check32("R6 raise wins from 0", {16'h0, pins}, {16'h0, b & MASK});
         bus_write(A_DATA, 32'hFFFF);
         bus_write(A_CMD, {b, b});
         check32("R6 raise wins from 1", {16'h0, pins}, {16'h0, MASK});
      end

      // R8: reserved raise and lower bits change nothing
      bus_write(A_DATA, 32'h0000_A05A);
      model = 16'hA05A & MASK;
      bus_write(A_CMD, 32'h0000_1F80);
      check32("R8 reserved raise bits", {16'h0, pins}, {16'h0, model});
      bus_write(A_DATA, 32'hFFFF);
      model = MASK;
      bus_write(A_CMD, 32'h1F80_0000);
      check32("R8 reserved lower bits", {16'h0, pins}, {16'h0, model});

      // R5 / R7: random command words against the model
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] d;
         d = $urandom();
         if (i % 3 == 0) d = d & $urandom();
         bus_write(A_CMD, d);
         model = apply_cmd(model, d);
         check32("R5 random command", {16'h0, pins}, {16'h0, model});
         if (i % 8 == 0) begin
            bus_read(A_CMD, rv);
            check32("R7 command word reads 0", rv, 32'h0);
         end
      end
      bus_write(A_CMD, 32'h0000_0000);
      check32("R5 all-zero command", {16'h0, pins}, {16'h0, model});
      bus_read(A_DATA, rv);
      check32("R5 data read after random", rv, {16'h0, model});

      // R10: every other word address plus unaligned neighbours
      for (int a = 0; a < 4096 + 6; a++) begin
         logic [11:0] ad;
         if (a < 4096) ad = 12'(a);
         else ad = 12'h812 + 12'(a - 4096) + ((a >= 4096 + 3) ? 12'd4 : 12'd0);
         if (ad == A_DATA || ad == A_CMD) continue;
         if (a < 4096 && (a % 4) != 0) continue;
         bus_write(ad, 32'hFFFF_FFFF);
         if (ad[3:0] == 4'h0) model = model;
         check32("R10 undefined write", {16'h0, pins}, {16'h0, model});
         bus_read(ad, rv);
         check32("R10 undefined read", rv, 32'h0);
      end

      // R10: read strobe low returns zero
      @(negedge clk);
      addr = A_DATA; rd_en = 1'b0;
      #1 check32("R10 idle read", rd_data, 32'h0);

      // R1: reset clears a non-zero port
      bus_write(A_DATA, 32'hFFFF);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      check32("R1 reset clears pins", {16'h0, pins}, 32'h0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule